// File: doc/BRIEF.md
# Skip and program interrupt controller

This block serves the I/O side of a small 18-bit processor. It has two jobs. The first is the skip path. Every device offers a ready flag level, and the processor decodes a per-device sense pulse from the low-order event-1 command of an I/O instruction. When a device's flag and that same device's sense pulse are both high, the block raises a skip strobe. The program counter logic uses this strobe to advance one extra word, so the next instruction is passed over.

The second job is the interrupt path. The controller forms the OR of the interrupt request levels. At the end of an instruction it decides whether to break into the running program. A break takes place only when the interrupt system is enabled and no break sequence is already running. It has two steps. First the block asks for one store to location 0 of a word that packs the link, the extend and trap mode bits and the 15-bit combined program counter. Then it forces the next fetch to come from location 1. Granting a break switches the interrupt system off. An enable command switches it back on after a delay of one instruction, so that a return jump placed right after the enable always completes. A disable command switches it off at once.

Top module: `skip_intr_ctrl`

## Requirements
- R1: `skip_o` is high in the same cycle in which, for some index k, both `dev_flag_i[k]` and `dev_sense_i[k]` are high. It is low whenever no sense pulse is high.
- R2: A flag that is paired only with a different device's sense pulse does not raise `skip_o`.
- R3: The interrupt request is the OR of all `N_IRQ` bits of `irq_i` (9 by default). Any single bit is enough to request a break.
- R4: A break is granted only on a clock edge where `instr_end_i` is high, the system is enabled and no break is running. `brk_store_o` is then high for exactly the one following cycle.
- R5: While `brk_store_o` is high, `brk_data_o` holds the state sampled on the grant edge: bit 0 = link, bit 1 = extend, bit 2 = trap, bits 17:3 = `pc_i`. The store targets location 0.
- R6: In the cycle after `brk_store_o`, `fetch_ovr_o` is high for one cycle with `fetch_addr_o` = 1. `fetch_addr_o` is 0 at all other times. The two strobes are never high together.
- R7: Granting a break disables the interrupt system. A request held high afterwards causes no further break until the system is enabled again.
- R8: After a pulse on `ion_i`, the system becomes enabled on the second `instr_end_i` edge that follows: the end of the enabling instruction, then the end of the one after it. A break can first be granted at the instruction end after that. If `ion_i` and `instr_end_i` arrive in the same cycle, that edge counts as the first end.
- R9: A pulse on `ioff_i` clears the enable and cancels a pending enable on the next edge. `ioff_i` takes priority over `ion_i`.
- R10: A request raised while the system is disabled stays pending as a level. It is granted at the first eligible instruction end once the system is enabled.
- R11: After reset the system is disabled and `skip_o`, `brk_store_o`, `fetch_ovr_o` and `fetch_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_flag_i | input | N_SKIP | Device ready flag levels |
| dev_sense_i | input | N_SKIP | Per-device sense pulses (event-1 command) |
| irq_i | input | N_IRQ | Interrupt request levels |
| instr_end_i | input | 1 | Strobe marking the last cycle of an instruction |
| ion_i | input | 1 | Interrupt enable command |
| ioff_i | input | 1 | Interrupt disable command |
| pc_i | input | 15 | Combined extended and program counter (return address) |
| link_i | input | 1 | Link bit |
| extend_i | input | 1 | Extend mode state |
| trap_i | input | 1 | Trap mode state |
| skip_o | output | 1 | Skip strobe |
| brk_store_o | output | 1 | Request to store `brk_data_o` at location 0 |
| brk_data_o | output | 18 | Saved state word |
| fetch_ovr_o | output | 1 | Force the next fetch to `fetch_addr_o` |
| fetch_addr_o | output | 15 | Forced fetch address (1 during the override) |

## Verification
The checker module watches several relations on every cycle. It confirms that no skip appears without a sense pulse. It confirms that a store strobe follows an instruction end that carried a request, and that the stored word matches the state sampled one edge earlier. It also confirms that the fetch override follows the store exactly one cycle later, with address 1, and never overlaps it. Other behaviours involve counts of instruction ends across whole command sequences, and only the bench scenarios can show them. These are the one-instruction enable delay, the cancellation of a pending enable by a disable, a request held through a disabled period, and the lockout after a grant. The bench's cycle model checks them along with a long randomised run.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int WORD_W = 18;
  localparam int PC_W   = 15;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STORE = 2'd1,
    ST_FETCH = 2'd2
  } brk_st_e;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_LAST = 2'd1,
    ARM_TWO  = 2'd2
  } arm_e;

  function automatic logic [WORD_W-1:0] pack_state(
    input logic            link,
    input logic            ext,
    input logic            trap,
    input logic [PC_W-1:0] pc
  );
    return {pc, trap, ext, link};
  endfunction
endpackage

// File: rtl/sic_skip_net.sv
module sic_skip_net #(
  parameter int N_DEV = 8
) (
  input  logic [N_DEV-1:0] flag_i,
  input  logic [N_DEV-1:0] sense_i,
  output logic             skip_o
);
  logic [N_DEV-1:0] hit;

  for (genvar k = 0; k < N_DEV; k++) begin : g_pair
    assign hit[k] = flag_i[k] & sense_i[k];
  end

  assign skip_o = |hit;
endmodule

// File: rtl/sic_enable_arm.sv
module sic_enable_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ion_i,
  input  logic ioff_i,
  input  logic instr_end_i,
  input  logic grant_i,
  output logic en_o
);
  import sic_pkg::*;

  arm_e arm_q, arm_d;
  logic en_q, en_d;

  always_comb begin
    arm_d = arm_q;
    en_d  = en_q;
    if (ioff_i || grant_i) begin
      en_d  = 1'b0;
      arm_d = ARM_NONE;
    end else if (ion_i) begin
      // an end in the same cycle belongs to the enabling instruction
      arm_d = instr_end_i ? ARM_LAST : ARM_TWO;
    end else if (instr_end_i) begin
      unique case (arm_q)
        ARM_TWO:  arm_d = ARM_LAST;
        ARM_LAST: begin
          arm_d = ARM_NONE;
          en_d  = 1'b1;
        end
        default:  arm_d = ARM_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= ARM_NONE;
      en_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/sic_brk_seq.sv
module sic_brk_seq #(
  parameter int N_IRQ = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       instr_end_i,
  input  logic                       en_i,
  input  logic [N_IRQ-1:0]           irq_i,
  input  logic                       link_i,
  input  logic                       extend_i,
  input  logic                       trap_i,
  input  logic [sic_pkg::PC_W-1:0]   pc_i,
  output logic                       grant_o,
  output logic                       store_o,
  output logic                       fetch_o,
  output logic [sic_pkg::WORD_W-1:0] data_o
);
  import sic_pkg::*;

  brk_st_e st_q, st_d;
  logic [WORD_W-1:0] data_q;
  logic req_any;

  assign req_any = |irq_i;
  assign grant_o = instr_end_i & en_i & req_any & (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (grant_o) st_d = ST_STORE;
      ST_STORE: st_d = ST_FETCH;
      ST_FETCH: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (grant_o) data_q <= pack_state(link_i, extend_i, trap_i, pc_i);
    end
  end

  assign store_o = (st_q == ST_STORE);
  assign fetch_o = (st_q == ST_FETCH);
  assign data_o  = data_q;
endmodule

// File: rtl/skip_intr_ctrl.sv
module skip_intr_ctrl #(
  parameter int N_SKIP = 8,
  parameter int N_IRQ  = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SKIP-1:0]          dev_flag_i,
  input  logic [N_SKIP-1:0]          dev_sense_i,
  input  logic [N_IRQ-1:0]           irq_i,
  input  logic                       instr_end_i,
  input  logic                       ion_i,
  input  logic                       ioff_i,
  input  logic [sic_pkg::PC_W-1:0]   pc_i,
  input  logic                       link_i,
  input  logic                       extend_i,
  input  logic                       trap_i,
  output logic                       skip_o,
  output logic                       brk_store_o,
  output logic [sic_pkg::WORD_W-1:0] brk_data_o,
  output logic                       fetch_ovr_o,
  output logic [sic_pkg::PC_W-1:0]   fetch_addr_o
);
  import sic_pkg::*;

  localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(1);

  logic en, grant, fetch;

  sic_skip_net #(.N_DEV(N_SKIP)) u_skip (
    .flag_i (dev_flag_i),
    .sense_i(dev_sense_i),
    .skip_o (skip_o)
  );

  sic_enable_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ion_i      (ion_i),
    .ioff_i     (ioff_i),
    .instr_end_i(instr_end_i),
    .grant_i    (grant),
    .en_o       (en)
  );

  sic_brk_seq #(.N_IRQ(N_IRQ)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_end_i(instr_end_i),
    .en_i       (en),
    .irq_i      (irq_i),
    .link_i     (link_i),
    .extend_i   (extend_i),
    .trap_i     (trap_i),
    .pc_i       (pc_i),
    .grant_o    (grant),
    .store_o    (brk_store_o),
    .fetch_o    (fetch),
    .data_o     (brk_data_o)
  );

  assign fetch_ovr_o  = fetch;
  assign fetch_addr_o = fetch ? VEC_ADDR : '0;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int N_SKIP = 8,
  parameter int N_IRQ  = 9
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_SKIP-1:0]          dev_sense_i,
  input logic [N_IRQ-1:0]           irq_i,
  input logic                       instr_end_i,
  input logic [sic_pkg::PC_W-1:0]   pc_i,
  input logic                       link_i,
  input logic                       extend_i,
  input logic                       trap_i,
  input logic                       skip_o,
  input logic                       brk_store_o,
  input logic [sic_pkg::WORD_W-1:0] brk_data_o,
  input logic                       fetch_ovr_o,
  input logic [sic_pkg::PC_W-1:0]   fetch_addr_o
);
  localparam int PW = sic_pkg::PC_W;

  a_r1_no_sense_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|dev_sense_i) |-> !skip_o);

  a_r4_store_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_store_o |-> ($past(instr_end_i) && $past(|irq_i)));

  a_r5_saved_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_store_o |-> (brk_data_o == {$past(pc_i), $past(trap_i), $past(extend_i), $past(link_i)}));

  a_r6_fetch_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_store_o |=> (fetch_ovr_o && fetch_addr_o == PW'(1)));

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_store_o && fetch_ovr_o));

  a_r7_no_rebreak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ovr_o |=> !brk_store_o);

  a_r6_addr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ovr_o |-> (fetch_addr_o == '0));
endmodule

bind skip_intr_ctrl sic_checker #(.N_SKIP(N_SKIP), .N_IRQ(N_IRQ)) u_sic_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_sense_i (dev_sense_i),
  .irq_i       (irq_i),
  .instr_end_i (instr_end_i),
  .pc_i        (pc_i),
  .link_i      (link_i),
  .extend_i    (extend_i),
  .trap_i      (trap_i),
  .skip_o      (skip_o),
  .brk_store_o (brk_store_o),
  .brk_data_o  (brk_data_o),
  .fetch_ovr_o (fetch_ovr_o),
  .fetch_addr_o(fetch_addr_o)
);

// File: tb/skip_intr_ctrl_bench.sv
`timescale 1ns/1ps
module skip_intr_ctrl_bench;
  localparam int NS = 8;
  localparam int NI = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] flag = '0, sense = '0;
  logic [NI-1:0] irq = '0;
  logic iend = 1'b0, ion = 1'b0, ioff = 1'b0;
  logic [14:0] pc = '0;
  logic link = 1'b0, ext = 1'b0, trap = 1'b0;
  logic skip, bstore, fovr;
  logic [17:0] bdata;
  logic [14:0] faddr;

  int n_chk = 0, n_fail = 0, n_store = 0;

  // reference model state
  bit m_en;
  int m_arm;
  int m_st;
  logic [17:0] m_word;

  always #4 clk = ~clk;

  skip_intr_ctrl #(.N_SKIP(NS), .N_IRQ(NI)) u_skip_intr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dev_flag_i(flag), .dev_sense_i(sense),
    .irq_i(irq), .instr_end_i(iend), .ion_i(ion), .ioff_i(ioff), .pc_i(pc),
    .link_i(link), .extend_i(ext), .trap_i(trap), .skip_o(skip),
    .brk_store_o(bstore), .brk_data_o(bdata), .fetch_ovr_o(fovr),
    .fetch_addr_o(faddr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_arm = 0; m_st = 0; m_word = '0;
    end else begin
      bit g;
      g = iend && m_en && (m_st == 0) && (irq != 0);
      if (g) m_word = {pc, trap, ext, link};
      if (g) m_st = 1; else if (m_st == 1) m_st = 2; else m_st = 0;
      if (ioff || g) begin m_en = 0; m_arm = 0; end
      else if (ion) m_arm = iend ? 1 : 2;
      else if (iend && m_arm == 1) begin m_en = 1; m_arm = 0; end
      else if (iend && m_arm == 2) m_arm = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [NS-1:0] f, input logic [NS-1:0] s, input logic [NI-1:0] q,
                       input bit e, input bit on, input bit off);
    flag = f; sense = s; irq = q; iend = e; ion = on; ioff = off;
    #1;
    check(skip === ((f & s) != 0), "R1 skip_o", skip, (f & s) != 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (bstore === 1'b1) n_store++;
    check(bstore === (m_st == 1), "R4 brk_store_o", bstore, m_st == 1);
    check(fovr === (m_st == 2), "R6 fetch_ovr_o", fovr, m_st == 2);
    check(faddr === ((m_st == 2) ? 15'd1 : 15'd0), "R6 fetch_addr_o", faddr, (m_st == 2) ? 1 : 0);
    if (m_st == 1) check(bdata === m_word, "R5 brk_data_o", bdata, m_word);
  endtask

  task automatic step(input logic [NI-1:0] q, input bit e, input bit on, input bit off);
    drive('0, '0, q, e, on, off);
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(bstore === 1'b0 && fovr === 1'b0 && faddr === '0, "R11 reset outputs", {bstore, fovr}, 0);
    rst_n = 1'b1;
    drive('0, '0, '0, 0, 0, 0);
    check(skip === 1'b0, "R11 skip after reset", skip, 0);
    tick();

    // R1 / R2 skip patterns
    drive(8'h08, 8'h08, '0, 0, 0, 0);
    check(skip === 1'b1, "R1 matched pair", skip, 1);
    drive(8'h08, 8'h04, '0, 0, 0, 0);
    check(skip === 1'b0, "R2 foreign sense", skip, 0);
    drive(8'hFF, 8'h00, '0, 0, 0, 0);
    check(skip === 1'b0, "R2 flags without sense", skip, 0);
    drive(8'h81, 8'h80, '0, 0, 0, 0);
    check(skip === 1'b1, "R1 top device", skip, 1);
    tick();

    // R11 disabled after reset: held request never breaks
    pc = 15'h1234; link = 1; ext = 0; trap = 1;
    for (int i = 0; i < 4; i++) step(9'h100, 1, 0, 0);
    check(n_store == 0, "R11 no break while disabled", n_store, 0);

    // R8 / R10 / R3 enable delay with pending top request bit
    step(9'h100, 0, 1, 0);
    step(9'h100, 1, 0, 0);  // end of enabling instruction
    step(9'h100, 1, 0, 0);  // end of following instruction
    check(n_store == 0, "R8 no break before delay elapses", n_store, 0);
    step(9'h100, 1, 0, 0);  // first eligible end
    check(n_store == 1, "R10 pending request granted", n_store, 1);
    step(9'h100, 0, 0, 0);

    // R7 lockout after grant
    base = n_store;
    for (int i = 0; i < 5; i++) step(9'h100, 1, 0, 0);
    check(n_store == base, "R7 no break after grant", n_store, base);

    // R9 disable cancels pending enable
    step(9'h001, 0, 1, 0);
    step(9'h001, 1, 0, 0);
    step(9'h001, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(9'h001, 1, 0, 0);
    check(n_store == base, "R9 pending enable cancelled", n_store, base);

    // R9 disable after enable took effect
    step('0, 1, 1, 0);      // ion with end in same cycle
    step('0, 1, 0, 0);      // enabled after this end
    step('0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(9'h010, 1, 0, 0);
    check(n_store == base, "R9 enabled system disabled", n_store, base);

    // R3 / R5 single low bit request, different saved state
    pc = 15'h7FFF; link = 0; ext = 1; trap = 0;
    step('0, 1, 1, 0);
    step('0, 1, 0, 0);
    step(9'h001, 1, 0, 0);
    check(n_store == base + 1, "R3 single request bit", n_store, base + 1);
    check(bdata === 18'h3FFFA, "R5 packed word", bdata, 18'h3FFFA);
    step('0, 0, 0, 0);

    // randomised run against model
    for (int i = 0; i < 3000; i++) begin
      flag = NS'($urandom); sense = NS'($urandom) & NS'($urandom);
      pc = 15'($urandom); link = 1'($urandom); ext = 1'($urandom); trap = 1'($urandom);
      drive(flag, sense, ($urandom % 3 == 0) ? NI'($urandom) : '0,
            ($urandom % 3) == 0, ($urandom % 12) == 0, ($urandom % 40) == 0);
      tick();
    end
    finish_run();
  end
endmodule